// File: doc/BRIEF.md
# Pi/4-Shifted Differential QPSK Symbol Modulator

This block turns a stream of two-bit symbols into baseband in-phase and quadrature amplitude levels for pi/4-shifted differential QPSK. At every symbol strobe that finds a valid dibit, the dibit selects a carrier phase step of plus or minus one or three eighths of a turn. That step is added to the phase sent on the previous symbol, and the new point's cosine and sine levels are presented on the outputs.

The phase is held as a three-bit count of eighth-turns and is converted to levels by a fixed table. Because of this, the rotation recursion never collects rounding error, however long the run. Every step is an odd number of eighths, so the transmitted point alternates between the on-axis and the diagonal QPSK set. The levels stay constant between accepted symbols and form rectangular pulses that a downstream shaping filter can use. With two bits per symbol, the strobe rate is half the data bit rate.

Top module: `dqpsk_symbol_mod`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the phase is 0, i_level reads AMP and q_level reads 0, where AMP = 2^(W-1) - 1 (2047 for the default W = 12).
- R2: A dibit is consumed only in a cycle where sym_stb and dibit_valid are both high. dibit_ready equals sym_stb in the same cycle. A valid dibit offered without the strobe changes nothing.
- R3: The dibit sets the phase step in eighths of a turn: 2'b00 gives +1, 2'b01 gives +3, 2'b11 gives -3 (that is, +5), and 2'b10 gives -1 (that is, +7).
- R4: For phase p, i_level = L(p) and q_level = L(p - 2 mod 8). Here L(0) = AMP, L(1) = L(7) = D, L(2) = L(6) = 0, L(3) = L(5) = -D and L(4) = -AMP, with D = floor((AMP*181 + 128)/256), which is 1447 by default.
- R5: When a dibit is consumed at a rising edge, the new levels appear at that same edge. Between consumed dibits both levels hold their values unchanged.
- R6: A strobe with dibit_valid low leaves the levels unchanged and does not advance the phase. The next consumed dibit rotates from the phase that was held.
- R7: After an odd number of consumed dibits since reset, both levels have magnitude D. After an even number, one level is 0 and the other is plus or minus AMP.
- R8: The phase wraps modulo 8 with no drift: eight consecutive 2'b00 dibits return the outputs exactly to i_level = AMP, q_level = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | Symbol strobe, one cycle per symbol period |
| dibit_valid | input | 1 | The dibit input holds a symbol |
| dibit | input | 2 | Symbol bits selecting the phase step |
| dibit_ready | output | 1 | The block takes the dibit this cycle |
| i_level | output | W | Signed in-phase level |
| q_level | output | W | Signed quadrature level |

## Verification
dibit_ready is combinational and is checked one time step after the inputs change, inside the same cycle. The levels are registered: a dibit driven at a falling edge is taken at the next rising edge, so the new I and Q are sampled at the falling edge that follows. Idle cycles between strobes are sampled at each falling edge to confirm that the levels do not move. During those idle cycles, valid dibits are offered without the strobe, and the level produced by the next real symbol shows that the phase did not advance.

// File: rtl/dqpsk_mod_pkg.sv
package dqpsk_mod_pkg;

    localparam int PH_BITS = 3;

    typedef logic [PH_BITS-1:0] phase_t;

    typedef enum logic [1:0] {
        SYM_P1 = 2'b00,
        SYM_P3 = 2'b01,
        SYM_M1 = 2'b10,
        SYM_M3 = 2'b11
    } dibit_e;

    // magnitude code: 0 zero, 1 diagonal, 2 full scale
    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } level_sel_t;

    function automatic phase_t shift_of(input dibit_e d);
        case (d)
            SYM_P1:  return phase_t'(1);
            SYM_P3:  return phase_t'(3);
            SYM_M3:  return phase_t'(5);
            default: return phase_t'(7);
        endcase
    endfunction

    function automatic level_sel_t cos_sel(input phase_t p);
        case (p)
            3'd0:    return '{neg: 1'b0, mag: 2'd2};
            3'd1:    return '{neg: 1'b0, mag: 2'd1};
            3'd2:    return '{neg: 1'b0, mag: 2'd0};
            3'd3:    return '{neg: 1'b1, mag: 2'd1};
            3'd4:    return '{neg: 1'b1, mag: 2'd2};
            3'd5:    return '{neg: 1'b1, mag: 2'd1};
            3'd6:    return '{neg: 1'b0, mag: 2'd0};
            default: return '{neg: 1'b0, mag: 2'd1};
        endcase
    endfunction

endpackage

// File: rtl/dqpsk_shift_map.sv
module dqpsk_shift_map
    import dqpsk_mod_pkg::*;
(
    input  logic [1:0] dibit,
    output phase_t     step
);
    always_comb step = shift_of(dibit_e'(dibit));
endmodule

// File: rtl/dqpsk_phase_acc.sv
module dqpsk_phase_acc
    import dqpsk_mod_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    input  phase_t step,
    output phase_t phase_q,
    output phase_t phase_nxt
);
    assign phase_nxt = phase_q + step;

    always_ff @(posedge clk) begin
        if (rst)          phase_q <= '0;
        else if (advance) phase_q <= phase_nxt;
    end

    // R6: an unconsumed cycle leaves the phase where it was
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(phase_q));

    // R7: every consumed symbol flips the set (odd step)
    p_set_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        advance |=> (phase_q[0] != $past(phase_q[0])));
endmodule

// File: rtl/dqpsk_level_lut.sv
module dqpsk_level_lut
    import dqpsk_mod_pkg::*;
#(
    parameter int W    = 12,
    parameter int AMP  = 2047,
    parameter int DIAG = 1447
) (
    input  phase_t               phase,
    output logic signed [W-1:0] cos_lvl,
    output logic signed [W-1:0] sin_lvl
);
    localparam logic signed [W-1:0] AMP_V  = W'(AMP);
    localparam logic signed [W-1:0] DIAG_V = W'(DIAG);

    logic signed [W-1:0] lv [2];

    for (genvar g = 0; g < 2; g++) begin : g_axis
        level_sel_t          sel;
        logic signed [W-1:0] mag_v;
        always_comb begin
            sel = cos_sel(phase_t'(phase - phase_t'(2 * g)));
            case (sel.mag)
                2'd0:    mag_v = '0;
                2'd1:    mag_v = DIAG_V;
                default: mag_v = AMP_V;
            endcase
            lv[g] = sel.neg ? -mag_v : mag_v;
        end
    end

    assign cos_lvl = lv[0];
    assign sin_lvl = lv[1];
endmodule

// File: rtl/dqpsk_symbol_mod.sv
module dqpsk_symbol_mod
    import dqpsk_mod_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sym_stb,
    input  logic                dibit_valid,
    input  logic [1:0]          dibit,
    output logic                dibit_ready,
    output logic signed [W-1:0] i_level,
    output logic signed [W-1:0] q_level
);
    localparam int AMP  = (1 << (W - 1)) - 1;
    localparam int DIAG = (AMP * 181 + 128) / 256;
    localparam logic signed [W-1:0] AMP_V = W'(AMP);

    logic                accept;
    phase_t              step;
    phase_t              phase_q;
    phase_t              phase_nxt;
    logic signed [W-1:0] cos_nxt;
    logic signed [W-1:0] sin_nxt;

    assign dibit_ready = sym_stb;
    assign accept      = sym_stb & dibit_valid;

    dqpsk_shift_map u_map (
        .dibit (dibit),
        .step  (step)
    );

    dqpsk_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .advance   (accept),
        .step      (step),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt)
    );

    dqpsk_level_lut #(.W(W), .AMP(AMP), .DIAG(DIAG)) u_lut (
        .phase   (phase_nxt),
        .cos_lvl (cos_nxt),
        .sin_lvl (sin_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            i_level <= AMP_V;
            q_level <= '0;
        end else if (accept) begin
            i_level <= cos_nxt;
            q_level <= sin_nxt;
        end
    end

    // R1: first cycle out of reset shows the phase-zero point
    p_reset_point_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (i_level == AMP_V && q_level == '0 && phase_q == '0));

    // R5: levels are held between consumed symbols
    p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(i_level) && $stable(q_level)));

    // R4: a point is either on an axis or on a diagonal
    p_point_shape_r4: assert property (@(posedge clk) disable iff (rst)
        (i_level == '0) || (q_level == '0) ||
        (i_level == q_level) || (i_level == -q_level));

    // R7: never both levels zero
    p_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        !(i_level == '0 && q_level == '0));
endmodule

// File: tb/dqpsk_symbol_mod_tb.sv
module dqpsk_symbol_mod_tb;
    localparam int W    = 12;
    localparam int AMP  = (1 << (W - 1)) - 1;
    localparam int DIAG = (AMP * 181 + 128) / 256;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                sym_stb = 1'b0;
    logic                dibit_valid = 1'b0;
    logic [1:0]          dibit = 2'b00;
    logic                dibit_ready;
    logic signed [W-1:0] i_level;
    logic signed [W-1:0] q_level;

    int checks = 0;
    int errors = 0;
    int ph     = 0;
    int taken  = 0;

    always #10 clk = ~clk;

    dqpsk_symbol_mod #(.W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .sym_stb     (sym_stb),
        .dibit_valid (dibit_valid),
        .dibit       (dibit),
        .dibit_ready (dibit_ready),
        .i_level     (i_level),
        .q_level     (q_level)
    );

    function automatic int lvl(input int k);
        case (((k % 8) + 8) % 8)
            0: return AMP;
            1: return DIAG;
            2: return 0;
            3: return -DIAG;
            4: return -AMP;
            5: return -DIAG;
            6: return 0;
            default: return DIAG;
        endcase
    endfunction

    function automatic int step_of(input logic [1:0] d);
        case (d)
            2'b00: return 1;
            2'b01: return 3;
            2'b11: return 5;
            default: return 7;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_point(input string req);
        chk(req, int'(i_level), lvl(ph));
        chk(req, int'(q_level), lvl(ph - 2));
    endtask

    // caller is at a falling edge
    task automatic send(input logic [1:0] d, input logic v, input string req);
        sym_stb     = 1'b1;
        dibit_valid = v;
        dibit       = d;
        #1;
        chk("R2 ready follows strobe", int'(dibit_ready), 1);
        @(negedge clk);
        sym_stb     = 1'b0;
        dibit_valid = 1'b0;
        if (v) begin
            ph = (ph + step_of(d)) % 8;
            taken++;
        end
        chk_point(req);
        if (taken % 2 == 1) begin
            chk("R7 diagonal set |I|", (i_level < 0) ? -int'(i_level) : int'(i_level), DIAG);
            chk("R7 diagonal set |Q|", (q_level < 0) ? -int'(q_level) : int'(q_level), DIAG);
        end else begin
            chk("R7 axis set has a zero", int'(i_level == 0 || q_level == 0), 1);
        end
    endtask

    // valid dibits without strobe must be ignored
    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            dibit_valid = 1'b1;
            dibit       = 2'($urandom);
            #1;
            chk("R2 ready low without strobe", int'(dibit_ready), 0);
            @(negedge clk);
            dibit_valid = 1'b0;
            chk_point("R5 hold between symbols");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 reset I", int'(i_level), AMP);
        chk("R1 reset Q", int'(q_level), 0);
        chk("R1 ready idle", int'(dibit_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk_point("R1 after reset");

        // R3: each dibit from a known phase
        send(2'b00, 1'b1, "R3 dibit 00 +1");
        send(2'b01, 1'b1, "R3 dibit 01 +3");
        send(2'b11, 1'b1, "R3 dibit 11 -3");
        send(2'b10, 1'b1, "R3 dibit 10 -1");
        idle(3);

        // R6: strobe without valid holds; next symbol from held phase
        send(2'b01, 1'b0, "R6 no valid holds");
        send(2'b01, 1'b1, "R6 rotate from held phase");
        idle(2);
        send(2'b10, 1'b1, "R5 after idle gap");

        // R8: back to zero then eight +1 steps
        while (ph != 0) send(2'b10, 1'b1, "R3 unwind");
        for (int k = 0; k < 8; k++) send(2'b00, 1'b1, "R8 wrap sequence");
        chk("R8 wrap I", int'(i_level), AMP);
        chk("R8 wrap Q", int'(q_level), 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            send(2'($urandom), ($urandom % 5) != 0, "R4 random symbol");
            idle($urandom % 4);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule